// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock. Each operand arrives as an unsigned bit field plus a separate sign bit. When the sign bit is set, the field holds the two's complement of the magnitude. The block first turns both operands into magnitudes and records the quotient sign. It then screens out three cases: a zero divisor, a quotient too wide for N bits, and a quotient that is trivially zero. Any of these finishes the operation early.

When no pre-check fires, the block runs N restoring shift-subtract steps. Each step shifts the partial remainder and quotient left together and trial-subtracts the divisor. If the difference is negative, the step adds the divisor back. After the last step, one rounding cycle may bump the quotient. A final cycle applies the sign. A single-cycle `done` pulse marks completion. The quotient, remainder, sign and flags stay on the outputs until the next completion.

Top module: `sm_divider`

## Requirements
- R1: Magnitudes are derived from the sign bits. A dividend field with its sign bit set has magnitude (2^(2N) - field) mod 2^(2N). A divisor field with its sign bit set has magnitude (2^N - field) mod 2^N. The quotient sign is the XOR of the two sign bits and appears on `quo_neg_o` at every completion.
- R2: A divisor magnitude of zero raises `dz_o` only. It takes priority over the overflow check. `done_o` pulses on the first clock edge after the edge that accepts `start_i`, with quotient and remainder driven to zero.
- R3: With a nonzero divisor, a high-half dividend magnitude greater than or equal to the divisor magnitude raises `ovf_o`. It completes with the same early timing as R2, and quotient and remainder are driven to zero.
- R4: With a zero high half and a low half below the divisor magnitude, the block raises `zero_o` and completes early. The quotient is 0 and the remainder is the low half, with no rounding applied.
- R5: In all other cases the quotient magnitude is floor(D/B) and the remainder is D mod B. `done_o` pulses on the (N+3)rd edge after the accepting edge.
- R6: After the N steps, the quotient magnitude gains 1 when twice the remainder is at least the divisor magnitude. The remainder output stays the unrounded value.
- R7: If the rounding increment carries out of N bits, the completion raises `ovf_o` and drives quotient and remainder to zero. The timing stays that of R5.
- R8: When the quotient sign is 1, `quo_o` is the two's complement (mod 2^N) of the quotient magnitude.
- R9: `done_o` is high for exactly one cycle. Quotient, remainder, sign and flags change only in the cycle `done_o` is high, and at most one flag is set.
- R10: `start_i` is ignored while an operation is in progress.
- R11: After reset, `done_o`, `quo_o`, `rem_o`, `quo_neg_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| dvd_hi_i | input | N | Upper half of the dividend field |
| dvd_lo_i | input | N | Lower half of the dividend field |
| dvd_neg_i | input | 1 | Dividend sign bit |
| dvs_i | input | N | Divisor field |
| dvs_neg_i | input | 1 | Divisor sign bit |
| done_o | output | 1 | One-cycle completion pulse |
| quo_o | output | N | Signed quotient (two's complement when negative) |
| rem_o | output | N | Remainder magnitude |
| quo_neg_o | output | 1 | Quotient sign |
| ovf_o | output | 1 | Quotient does not fit in N bits |
| dz_o | output | 1 | Divisor magnitude is zero |
| zero_o | output | 1 | Quotient resolved as zero by the shortcut |

## Verification
The bench targets these corner cases:

- **Zero divisor with a nonzero high half.** A design that ordered the pre-checks wrongly would report overflow here.
- **Negative-signed divisor field of zero.** A design that skipped the conversion before the zero test would miss this case.
- **Small dividend whose remainder would round.** A design that rounded on the shortcut path would return 1 instead of 0.
- **Quotient of all ones that rounds up.** A design without the carry check would silently return 0.
- **Each sign combination.** A misplaced complement would show up as a wrong quotient bit pattern.
- **Second start during a run.** A design that did not ignore it would corrupt the running result.
- **Latency and pulse width.** These are checked every cycle, so an extra or missing step would be caught.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PREP  = 3'd1,
        ST_ITER  = 3'd2,
        ST_ROUND = 3'd3,
        ST_SIGN  = 3'd4
    } dstate_e;

    typedef struct packed {
        logic ovf;
        logic dz;
        logic zero;
    } dflags_t;

endpackage

// File: rtl/sm_mag_conv.sv
// Conditional two's complement: turns a signed field into its magnitude.
module sm_mag_conv #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         neg_i,
    output logic [W-1:0] mag_o
);
    logic [W-1:0] inv;

    generate
        if (W == 1) begin : g_narrow
            assign inv = val_i;
        end else begin : g_wide
            assign inv = ~val_i + W'(1);
        end
    endgenerate

    assign mag_o = neg_i ? inv : val_i;
endmodule

// File: rtl/sm_div_step.sv
// One restoring iteration: shift left, trial subtract, add back if negative.
module sm_div_step #(
    parameter int N = 8
) (
    input  logic [N-1:0] rem_i,
    input  logic [N-1:0] quo_i,
    input  logic [N-1:0] dvs_i,
    output logic [N-1:0] rem_o,
    output logic [N-1:0] quo_o
);
    logic [N:0] shifted;
    logic [N:0] trial;
    logic [N:0] restored;
    logic       neg;

    assign shifted  = {rem_i, quo_i[N-1]};
    assign trial    = shifted - {1'b0, dvs_i};
    assign neg      = trial[N];
    assign restored = trial + {1'b0, dvs_i};
    assign rem_o    = neg ? restored[N-1:0] : trial[N-1:0];
    assign quo_o    = {quo_i[N-2:0], ~neg};
endmodule

// File: rtl/sm_round.sv
// Rounding: increment the quotient when twice the remainder reaches the divisor.
module sm_round #(
    parameter int N = 8
) (
    input  logic [N-1:0] rem_i,
    input  logic [N-1:0] quo_i,
    input  logic [N-1:0] dvs_i,
    output logic [N-1:0] quo_o,
    output logic         carry_o
);
    logic       up;
    logic [N:0] sum;

    assign up      = {rem_i, 1'b0} >= {1'b0, dvs_i};
    assign sum     = {1'b0, quo_i} + (N+1)'(up);
    assign quo_o   = sum[N-1:0];
    assign carry_o = sum[N];
endmodule

// File: rtl/sm_divider.sv
module sm_divider
    import sm_div_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [N-1:0] dvd_hi_i,
    input  logic [N-1:0] dvd_lo_i,
    input  logic         dvd_neg_i,
    input  logic [N-1:0] dvs_i,
    input  logic         dvs_neg_i,
    output logic         done_o,
    output logic [N-1:0] quo_o,
    output logic [N-1:0] rem_o,
    output logic         quo_neg_o,
    output logic         ovf_o,
    output logic         dz_o,
    output logic         zero_o
);
    localparam int W2 = 2 * N;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        dstate_e      st;
        logic [CW-1:0] cnt;
        logic [N-1:0] a;
        logic [N-1:0] q;
        logic [N-1:0] b;
        logic         an;
        logic         bn;
        logic         qs;
        logic         rc;
        logic         done;
        logic [N-1:0] quo;
        logic [N-1:0] rem;
        logic         qneg;
        dflags_t      fl;
    } regs_t;

    regs_t r_q, r_d;

    logic [W2-1:0] dmag;
    logic [N-1:0]  bmag;
    logic [N-1:0]  stp_rem, stp_quo;
    logic [N-1:0]  rnd_quo;
    logic          rnd_c;

    sm_mag_conv #(.W(W2)) u_dvd_mag (
        .val_i ({r_q.a, r_q.q}),
        .neg_i (r_q.an),
        .mag_o (dmag)
    );

    sm_mag_conv #(.W(N)) u_dvs_mag (
        .val_i (r_q.b),
        .neg_i (r_q.bn),
        .mag_o (bmag)
    );

    sm_div_step #(.N(N)) u_step (
        .rem_i (r_q.a),
        .quo_i (r_q.q),
        .dvs_i (r_q.b),
        .rem_o (stp_rem),
        .quo_o (stp_quo)
    );

    sm_round #(.N(N)) u_round (
        .rem_i   (r_q.a),
        .quo_i   (r_q.q),
        .dvs_i   (r_q.b),
        .quo_o   (rnd_quo),
        .carry_o (rnd_c)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.a  = dvd_hi_i;
                    r_d.q  = dvd_lo_i;
                    r_d.b  = dvs_i;
                    r_d.an = dvd_neg_i;
                    r_d.bn = dvs_neg_i;
                    r_d.rc = 1'b0;
                    r_d.st = ST_PREP;
                end
            end
            ST_PREP: begin
                r_d.a   = dmag[W2-1:N];
                r_d.q   = dmag[N-1:0];
                r_d.b   = bmag;
                r_d.qs  = r_q.an ^ r_q.bn;
                r_d.cnt = '0;
                if (bmag == '0) begin
                    r_d.fl.dz   = 1'b1;
                    r_d.fl.ovf  = 1'b0;
                    r_d.fl.zero = 1'b0;
                    r_d.quo     = '0;
                    r_d.rem     = '0;
                    r_d.qneg    = r_q.an ^ r_q.bn;
                    r_d.done    = 1'b1;
                    r_d.st      = ST_IDLE;
                end else if (dmag[W2-1:N] >= bmag) begin
                    r_d.fl.dz   = 1'b0;
                    r_d.fl.ovf  = 1'b1;
                    r_d.fl.zero = 1'b0;
                    r_d.quo     = '0;
                    r_d.rem     = '0;
                    r_d.qneg    = r_q.an ^ r_q.bn;
                    r_d.done    = 1'b1;
                    r_d.st      = ST_IDLE;
                end else if ((dmag[W2-1:N] == '0) && (dmag[N-1:0] < bmag)) begin
                    r_d.fl.dz   = 1'b0;
                    r_d.fl.ovf  = 1'b0;
                    r_d.fl.zero = 1'b1;
                    r_d.quo     = '0;
                    r_d.rem     = dmag[N-1:0];
                    r_d.qneg    = r_q.an ^ r_q.bn;
                    r_d.done    = 1'b1;
                    r_d.st      = ST_IDLE;
                end else begin
                    r_d.st = ST_ITER;
                end
            end
            ST_ITER: begin
                r_d.a   = stp_rem;
                r_d.q   = stp_quo;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(N - 1)) begin
                    r_d.st = ST_ROUND;
                end
            end
            ST_ROUND: begin
                r_d.q  = rnd_quo;
                r_d.rc = rnd_c;
                r_d.st = ST_SIGN;
            end
            ST_SIGN: begin
                r_d.fl.ovf  = r_q.rc;
                r_d.fl.dz   = 1'b0;
                r_d.fl.zero = 1'b0;
                if (r_q.rc) begin
                    r_d.quo = '0;
                    r_d.rem = '0;
                end else begin
                    r_d.quo = r_q.qs ? (~r_q.q + N'(1)) : r_q.q;
                    r_d.rem = r_q.a;
                end
                r_d.qneg = r_q.qs;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign quo_o     = r_q.quo;
    assign rem_o     = r_q.rem;
    assign quo_neg_o = r_q.qneg;
    assign ovf_o     = r_q.fl.ovf;
    assign dz_o      = r_q.fl.dz;
    assign zero_o    = r_q.fl.zero;
endmodule

// File: rtl/sm_divider_chk.sv
module sm_divider_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [N-1:0] dvs_i,
    input logic         dvs_neg_i,
    input logic         done_o,
    input logic [N-1:0] quo_o,
    input logic [N-1:0] rem_o,
    input logic         quo_neg_o,
    input logic         ovf_o,
    input logic         dz_o,
    input logic         zero_o
);
    logic         busy;
    int unsigned  age;
    logic [N-1:0] bcap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            age  <= 0;
            bcap <= '0;
        end else if (start_i && (!busy || done_o)) begin
            busy <= 1'b1;
            age  <= 0;
            bcap <= dvs_neg_i ? (~dvs_i + N'(1)) : dvs_i;
        end else if (done_o) begin
            busy <= 1'b0;
        end else if (busy) begin
            age <= age + 1;
        end
    end

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: never more than one flag
    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, dz_o, zero_o}));

    // R9: results move only with done
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({quo_o, rem_o, quo_neg_o, ovf_o, dz_o, zero_o}));

    // R5, R10: done arrives only after an accepted start, at one of two latencies
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy && ((age == 1) || (age == N + 3))));

    // R2: zero divisor finishes early
    a_r2_dz_early: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_o) |-> (age == 1));

    // R4: shortcut gives a zero quotient
    a_r4_zero_quo: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_o) |-> (quo_o == '0));

    // R5: remainder below divisor magnitude on valid results
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o && !dz_o) |-> (rem_o < bcap));
endmodule

bind sm_divider sm_divider_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .dvs_i     (dvs_i),
    .dvs_neg_i (dvs_neg_i),
    .done_o    (done_o),
    .quo_o     (quo_o),
    .rem_o     (rem_o),
    .quo_neg_o (quo_neg_o),
    .ovf_o     (ovf_o),
    .dz_o      (dz_o),
    .zero_o    (zero_o)
);

// File: tb/sim_sm_divider.sv
module sim_sm_divider;
    localparam int N    = 8;
    localparam int LONG = N + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] hi = '0, lo = '0, dv = '0;
    logic         dn = 1'b0, bn = 1'b0;
    logic         done, qneg, ovf, dz, zero;
    logic [N-1:0] quo, rem;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    sm_divider #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dvd_hi_i(hi), .dvd_lo_i(lo), .dvd_neg_i(dn),
        .dvs_i(dv), .dvs_neg_i(bn),
        .done_o(done), .quo_o(quo), .rem_o(rem), .quo_neg_o(qneg),
        .ovf_o(ovf), .dz_o(dz), .zero_o(zero)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Behavioural reference: whole-number division on magnitudes.
    task automatic model(input longint h, input longint l, input bit dneg,
                         input longint b, input bit bneg,
                         output int lat, output longint eq, output longint er,
                         output bit eneg, output bit eov, output bit edz, output bit ez);
        longint m1 = longint'(1) << N;
        longint m2 = longint'(1) << (2 * N);
        longint dm = h * m1 + l;
        longint bm = b;
        longint qq, rr;
        if (dneg) dm = (m2 - dm) % m2;
        if (bneg) bm = (m1 - bm) % m1;
        eneg = dneg ^ bneg;
        eq = 0; er = 0; eov = 0; edz = 0; ez = 0; lat = 1;
        if (bm == 0) begin
            edz = 1;
        end else if (dm / m1 >= bm) begin
            eov = 1;
        end else if (dm / m1 == 0 && dm % m1 < bm) begin
            ez = 1;
            er = dm % m1;
        end else begin
            lat = LONG;
            qq = dm / bm;
            rr = dm % bm;
            if (2 * rr >= bm) qq++;
            if (qq == m1) eov = 1;
            else begin
                eq = eneg ? (m1 - qq) % m1 : qq;
                er = rr;
            end
        end
    endtask

    task automatic run_op(input string req, input longint h, input longint l, input bit dneg,
                          input longint b, input bit bneg, input bit intrude);
        int lat;
        longint eq, er;
        bit eneg, eov, edz, ez;
        model(h, l, dneg, b, bneg, lat, eq, er, eneg, eov, edz, ez);
        @(negedge clk);
        start = 1'b1; hi = N'(h); lo = N'(l); dn = dneg; dv = N'(b); bn = bneg;
        @(negedge clk);
        start = 1'b0;
        chk(req, "done before start taken", longint'(done), 0);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (intrude && k == 2) begin
                // R10: a second start while busy must change nothing
                start = 1'b1; hi = '0; lo = 8'd3; dv = 8'd1; dn = 1'b1; bn = 1'b1;
            end else begin
                start = 1'b0;
            end
            chk(k == lat ? req : "R9", "done timing", longint'(done), longint'(k == lat));
        end
        start = 1'b0;
        chk("R9", "ovf flag", longint'(ovf), longint'(eov));
        chk("R2", "dz flag", longint'(dz), longint'(edz));
        chk("R4", "zero flag", longint'(zero), longint'(ez));
        chk("R1", "quotient sign", longint'(qneg), longint'(eneg));
        if (!eov && !edz) begin
            chk(req, "quotient", longint'(quo), eq);
            chk(req, "remainder", longint'(rem), er);
        end
        @(negedge clk);
        chk("R9", "done pulse width", longint'(done), 0);
        if (!eov && !edz) chk("R9", "quotient held", longint'(quo), eq);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "done", longint'(done), 0);
        chk("R11", "quotient", longint'(quo), 0);
        chk("R11", "remainder", longint'(rem), 0);
        chk("R11", "flags", longint'({qneg, ovf, dz, zero}), 0);

        run_op("R6", 3, 232, 0, 7, 0, 0);       // 1000/7 -> 142 r6, rounds to 143
        run_op("R5", 3, 232, 0, 9, 0, 0);       // 1000/9 -> 111 r1
        run_op("R8", 252, 24, 1, 9, 0, 0);      // -1000/9 -> -111
        run_op("R8", 3, 232, 0, 247, 1, 0);     // 1000/-9
        run_op("R1", 252, 24, 1, 247, 1, 0);    // -1000/-9 -> +111
        run_op("R2", 5, 0, 0, 0, 0, 0);         // zero divisor beats overflow
        run_op("R1", 1, 2, 0, 0, 1, 0);         // negative zero divisor field
        run_op("R3", 10, 0, 0, 10, 0, 0);       // high half equals divisor
        run_op("R3", 10, 0, 0, 11, 0, 0);       // just below overflow
        run_op("R4", 0, 5, 0, 7, 0, 0);         // shortcut, no rounding to 1
        run_op("R4", 255, 251, 1, 7, 0, 0);     // negative small dividend
        run_op("R7", 199, 206, 0, 200, 0, 0);   // 255 rounds to 256
        run_op("R10", 3, 232, 0, 7, 0, 1);      // start ignored while busy

        for (int i = 0; i < 80; i++) begin
            longint rh, rl, rb;
            bit rdn, rbn;
            seed = seed * 32'd1103515245 + 32'd12345;
            rb = (seed >> 8) & 255;
            rl = (seed >> 16) & 255;
            rdn = seed[30];
            rbn = seed[29];
            seed = seed * 32'd1103515245 + 32'd12345;
            rh = (rb > 1 && seed[31]) ? ((seed >> 8) % rb) : ((seed >> 8) & 255);
            run_op("R5", rh, rl, rdn, rb, rbn, seed[27]);
        end

        summary();
        $finish;
    end
endmodule